// File: doc/BRIEF.md
# Multi-Byte Stack Transfer Engine

This block moves a register image between the datapath and a byte-wide stack in memory. The length of each move is variable. A one-cycle start pulse carries a direction (push or pull), a 64-bit value to store and a byte-count operand taken from the instruction stream. The engine then performs one memory byte access per clock and updates its own 16-bit stack pointer. On a pull it rebuilds the register from the bytes it reads. One cycle after the last byte it signals completion.

The count operand selects `n+1` bytes. Operands above 7 are saturated to 7, so a full 64-bit image is the longest move. A push stores the most significant selected byte first and the least significant byte last. A pull reads back in little-endian order, so the pull of the same length that follows a push restores the same value. Choosing the architectural register and fetching the operand are left to the surrounding control.

Memory read data is expected combinationally, in the same cycle as the read strobe and its address.

Top module: `stk_transfer_engine`

## Requirements
- R1: A count operand greater than 7 behaves exactly like 7. Operand n (0..7) moves n+1 bytes, one byte per clock cycle, on consecutive cycles.
- R2: A push of n+1 bytes writes byte lane n (bits [8n+7:8n]) in the first cycle and then lanes n-1 and lower in descending order. Lane 0 (bits [7:0]) is written last.
- R3: Each push write goes to the address equal to the current stack pointer, and the pointer then decrements by one. After a push the pointer is lower by n+1.
- R4: Each pull first increments the stack pointer and then reads at the new pointer value. The first byte read lands in bits [7:0], the second in bits [15:8], and so on.
- R5: After a pull of n+1 bytes, all result bits above bit 8n+7 are zero, whatever the previous result held.
- R6: After reset the stack pointer is 0xFFFF. It wraps modulo 65536 in both directions, and it does not change while no transfer is in progress.
- R7: busy_o is high in exactly the cycles that carry a byte transfer. done_o is high for one cycle, in the cycle after the last transfer, and busy_o is low in that cycle.
- R8: A start pulse that arrives while transfers are in progress, or in the done cycle, is ignored. It does not change the pointer, the memory strobes or the length, direction or data of the move under way.
- R9: pull_val_o holds the result of the most recent pull. A push leaves it unchanged. After reset it is zero.
- R10: Push cycles assert only mem_we_o and pull cycles assert only mem_re_o. Outside transfer cycles neither strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a move, honoured only when idle |
| dir_i | input | 1 | 0 = push, 1 = pull |
| value_i | input | 64 | Register image to push, captured with start |
| count_i | input | 8 | Byte-count operand (bytes = min(count,7)+1) |
| mem_addr_o | output | 16 | Stack byte address of the current access |
| mem_we_o | output | 1 | Byte write strobe |
| mem_wdata_o | output | 8 | Byte written on a push |
| mem_re_o | output | 1 | Byte read strobe |
| mem_rdata_i | input | 8 | Byte returned for the current read, same cycle |
| pull_val_o | output | 64 | Value rebuilt by the latest pull |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | High during byte-transfer cycles |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every operand from 0 to 9 in both directions and runs each push against a pull of the same length. A wrong clamp would move too many or too few bytes, and the round-trip value would then come back corrupted. A byte-order error would write a lane at the wrong address, and a pointer that read before incrementing would fetch the byte one address too low. Moves that cross address 0x0000 in both directions catch a pointer that saturates instead of wrapping. A short pull after a full-width one exposes stale upper bits left in the result. Start pulses injected in the middle of a move and in the done cycle would, if honoured, change the pointer, the strobes or the length of the move.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_DATA_W = 64;
    localparam int STK_BYTE_W = 8;
    localparam int STK_SP_W   = 16;
    localparam int STK_OP_W   = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MOVE = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef enum logic {
        XFER_PUSH = 1'b0,
        XFER_PULL = 1'b1
    } xfer_dir_e;

    // One byte-transfer slot as seen by the pointer and assembler
    typedef struct packed {
        logic      valid;
        logic      first;
        logic      last;
        xfer_dir_e dir;
    } step_t;

    // Saturate the in-stream operand to the largest lane index
    function automatic int unsigned clamp_count(input int unsigned op,
                                                input int unsigned top);
        return (op > top) ? top : op;
    endfunction

endpackage

// File: rtl/stk_sequencer.sv
module stk_sequencer
    import stk_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int OP_W   = 8,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  xfer_dir_e        dir_i,
    input  logic [OP_W-1:0]  count_i,
    output step_t            step_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             idle_o,
    output logic             busy_o,
    output logic             done_o
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] span_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W:0]   beats_q;
    xfer_dir_e        dir_q;
    logic             first_q;
    logic [CNT_W-1:0] span_in;

    assign span_in = CNT_W'(clamp_count(32'(count_i), NBYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            span_q  <= '0;
            rem_q   <= '0;
            beats_q <= '0;
            dir_q   <= XFER_PUSH;
            first_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_MOVE;
                        span_q  <= span_in;
                        rem_q   <= span_in;
                        dir_q   <= dir_i;
                        first_q <= 1'b1;
                        beats_q <= '0;
                    end
                end
                SEQ_MOVE: begin
                    first_q <= 1'b0;
                    beats_q <= beats_q + 1'b1;
                    if (rem_q == '0) begin
                        state_q <= SEQ_DONE;
                    end else begin
                        rem_q <= rem_q - 1'b1;
                    end
                end
                SEQ_DONE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        step_o.valid = (state_q == SEQ_MOVE);
        step_o.first = first_q;
        step_o.last  = (rem_q == '0);
        step_o.dir   = dir_q;
        // Push walks lanes downward, pull walks them upward
        idx_o = (dir_q == XFER_PUSH) ? rem_q : (span_q - rem_q);
    end

    assign idle_o = (state_q == SEQ_IDLE);
    assign busy_o = (state_q == SEQ_MOVE);
    assign done_o = (state_q == SEQ_DONE);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // Move length equals clamped operand plus one (R1)
    p_move_length_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (beats_q == (CNT_W+1)'(span_q) + 1'b1));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !step_o.last) |=>
            (busy_o && $stable(span_q) && (dir_q == $past(dir_q))));

endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
    import stk_pkg::*;
#(
    parameter int              SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  step_t           step_i,
    output logic [SP_W-1:0] sp_o,
    output logic [SP_W-1:0] addr_o
);

    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_INIT;
        end else if (step_i.valid) begin
            if (step_i.dir == XFER_PUSH) begin
                sp_q <= sp_q - 1'b1;
            end else begin
                sp_q <= sp_q + 1'b1;
            end
        end
    end

    // Push uses the pointer as is; pull uses the pre-incremented value
    assign addr_o = (step_i.dir == XFER_PULL) ? (sp_q + 1'b1) : sp_q;
    assign sp_o   = sp_q;

    p_push_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i.valid && step_i.dir == XFER_PUSH) |=> (sp_o == $past(sp_o) - 1'b1));

    p_pull_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i.valid && step_i.dir == XFER_PULL) |=> (sp_o == $past(addr_o)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step_i.valid |=> $stable(sp_o));

endmodule

// File: rtl/stk_pull_assembler.sv
module stk_pull_assembler
    import stk_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 8,
    localparam int CNT_W  = $clog2(NBYTES),
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [DATA_W-1:0] val_o
);

    logic [NBYTES-1:0][BYTE_W-1:0] lane_q;
    logic                          take;

    assign take = step_i.valid && (step_i.dir == XFER_PULL);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (take) begin
                if (idx_i == CNT_W'(g)) begin
                    lane_q[g] <= rdata_i;
                end else if (step_i.first) begin
                    // First pulled byte replaces the whole register
                    lane_q[g] <= '0;
                end
            end
        end
    end

    assign val_o = lane_q;

    p_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (take && step_i.first) |=> (val_o[DATA_W-1:BYTE_W] == '0));

    p_push_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(val_o));

endmodule

// File: rtl/stk_transfer_engine.sv
module stk_transfer_engine
    import stk_pkg::*;
#(
    parameter int              DATA_W  = STK_DATA_W,
    parameter int              BYTE_W  = STK_BYTE_W,
    parameter int              SP_W    = STK_SP_W,
    parameter int              OP_W    = STK_OP_W,
    parameter logic [SP_W-1:0] SP_INIT = '1,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int CNT_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic [OP_W-1:0]   count_i,
    output logic [SP_W-1:0]   mem_addr_o,
    output logic              mem_we_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_re_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] pull_val_o,
    output logic [SP_W-1:0]   sp_o,
    output logic              busy_o,
    output logic              done_o
);

    step_t                         step;
    logic [CNT_W-1:0]              idx;
    logic                          idle;
    logic [NBYTES-1:0][BYTE_W-1:0] push_q;

    stk_sequencer #(
        .NBYTES (NBYTES),
        .OP_W   (OP_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .dir_i   (xfer_dir_e'(dir_i)),
        .count_i (count_i),
        .step_o  (step),
        .idx_o   (idx),
        .idle_o  (idle),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    stk_pointer #(
        .SP_W    (SP_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .sp_o   (sp_o),
        .addr_o (mem_addr_o)
    );

    stk_pull_assembler #(
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step),
        .idx_i   (idx),
        .rdata_i (mem_rdata_i),
        .val_o   (pull_val_o)
    );

    // Push image is captured only when a start is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            push_q <= '0;
        end else if (start_i && idle) begin
            push_q <= value_i;
        end
    end

    assign mem_wdata_o = push_q[idx];
    assign mem_we_o    = step.valid && (step.dir == XFER_PUSH);
    assign mem_re_o    = step.valid && (step.dir == XFER_PULL);

    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o || mem_re_o) |-> busy_o);

    p_push_image_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(push_q));

endmodule

// File: tb/tb_stk_transfer_engine.sv
`timescale 1ns/1ps
module tb_stk_transfer_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir;
    logic [63:0] value;
    logic [7:0]  count;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic [63:0] pull_val;
    logic [15:0] sp;
    logic        busy;
    logic        done;

    logic [7:0]  mem [256];
    logic [15:0] sp_m;
    logic [63:0] last_pull;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    stk_transfer_engine dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .dir_i       (dir),
        .value_i     (value),
        .count_i     (count),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .mem_re_o    (mem_re),
        .mem_rdata_i (mem_rdata),
        .pull_val_o  (pull_val),
        .sp_o        (sp),
        .busy_o      (busy),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_mask(input int c);
        return (c >= 7) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (c + 1))) - 64'd1);
    endfunction

    // One move; poke injects stray start pulses mid-move and in the done cycle
    task automatic run_op(input bit pull, input logic [63:0] v, input logic [7:0] cnt,
                          input bit poke);
        int c;
        logic [63:0] exp_val;
        c = (cnt > 8'd7) ? 7 : int'(cnt);
        exp_val = '0;
        @(negedge clk);
        start = 1'b1; dir = pull; value = v; count = cnt;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= c; k++) begin
            if (poke && k == 0) begin
                start = 1'b1; dir = ~pull; value = ~v; count = 8'd0;
            end else begin
                start = 1'b0;
            end
            chk(busy && !done, "R7 busy during transfer", {62'd0, busy, done}, 64'd2);
            if (!pull) begin
                chk(mem_we && !mem_re, "R10 push strobes", {62'd0, mem_we, mem_re}, 64'd2);
                chk(mem_addr == sp_m, "R3 push address", 64'(mem_addr), 64'(sp_m));
                chk(mem_wdata == v[(c - k) * 8 +: 8], "R2 push byte order",
                    64'(mem_wdata), 64'(v[(c - k) * 8 +: 8]));
                mem[sp_m[7:0]] = v[(c - k) * 8 +: 8];
                sp_m = sp_m - 16'd1;
            end else begin
                chk(mem_re && !mem_we, "R10 pull strobes", {62'd0, mem_we, mem_re}, 64'd1);
                sp_m = sp_m + 16'd1;
                chk(mem_addr == sp_m, "R4 pull address", 64'(mem_addr), 64'(sp_m));
                exp_val[k * 8 +: 8] = mem[sp_m[7:0]];
            end
            @(negedge clk);
        end
        start = poke;
        chk(done && !busy, "R7 done pulse", {62'd0, busy, done}, 64'd1);
        chk(sp == sp_m, "R1 R3 R6 pointer after move", 64'(sp), 64'(sp_m));
        if (pull) begin
            chk(pull_val == exp_val, "R4 R5 pulled value", pull_val, exp_val);
            last_pull = exp_val;
        end else begin
            chk(pull_val == last_pull, "R9 push keeps result", pull_val, last_pull);
        end
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy && !mem_we && !mem_re, "R8 R10 idle after done",
            {60'd0, done, busy, mem_we, mem_re}, 64'd0);
        chk(sp == sp_m, "R8 pointer unchanged by stray start", 64'(sp), 64'(sp_m));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        rst = 1'b1; start = 1'b0; dir = 1'b0; value = '0; count = '0;
        sp_m = 16'hFFFF; last_pull = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sp == 16'hFFFF, "R6 reset pointer", 64'(sp), 64'hFFFF);
        chk(!busy && !done && !mem_we && !mem_re, "R7 reset idle",
            {60'd0, busy, done, mem_we, mem_re}, 64'd0);
        chk(pull_val == '0, "R9 reset result", pull_val, 64'd0);

        // R1: operands 0..9, push then pull of the same length round-trips
        for (int n = 0; n < 10; n++) begin
            int c;
            c = (n > 7) ? 7 : n;
            v = 64'h0123_4567_89AB_CDEF ^ (64'h1111_1111_1111_1111 * 64'(n + 1));
            run_op(1'b0, v, 8'(n), 1'b0);
            chk(sp == 16'hFFFF - 16'(c + 1), "R1 clamped push length",
                64'(sp), 64'(16'hFFFF - 16'(c + 1)));
            run_op(1'b1, 64'd0, 8'(n), 1'b0);
            chk(pull_val == (v & lane_mask(c)), "R1 R4 round trip",
                pull_val, v & lane_mask(c));
        end
        chk(sp == 16'hFFFF, "R3 R4 pointer balanced", 64'(sp), 64'hFFFF);

        // Large operand clamps to a full-width move
        run_op(1'b0, 64'hFEDC_BA98_7654_3210, 8'hFF, 1'b0);
        run_op(1'b1, 64'd0, 8'h80, 1'b0);
        chk(pull_val == 64'hFEDC_BA98_7654_3210, "R1 operand 0xFF/0x80 full width",
            pull_val, 64'hFEDC_BA98_7654_3210);

        // R6: upward wrap through 0x0000
        run_op(1'b1, 64'd0, 8'd3, 1'b0);
        chk(sp == 16'h0003, "R6 pull wraps upward", 64'(sp), 64'h0003);
        // R6: downward wrap through 0x0000
        run_op(1'b0, 64'hA5B6_C7D8_E9FA_0B1C, 8'd7, 1'b0);
        chk(sp == 16'hFFFB, "R6 push wraps downward", 64'(sp), 64'hFFFB);
        run_op(1'b1, 64'd0, 8'd7, 1'b0);
        chk(pull_val == 64'hA5B6_C7D8_E9FA_0B1C, "R6 wrap round trip",
            pull_val, 64'hA5B6_C7D8_E9FA_0B1C);

        // R5: short pull after a full-width result clears upper bits
        run_op(1'b1, 64'd0, 8'd0, 1'b0);
        chk(pull_val[63:8] == '0, "R5 upper bits cleared", pull_val, pull_val & 64'hFF);
        run_op(1'b1, 64'd0, 8'd2, 1'b0);
        chk(pull_val[63:24] == '0, "R5 upper bits cleared 3 bytes",
            pull_val, pull_val & 64'hFF_FFFF);

        // R8: stray starts during and after a move
        run_op(1'b0, 64'h1357_9BDF_2468_ACE0, 8'd5, 1'b1);
        run_op(1'b1, 64'd0, 8'd5, 1'b1);
        chk(pull_val == 64'h0000_9BDF_2468_ACE0, "R8 stray start round trip",
            pull_val, 64'h0000_9BDF_2468_ACE0);
        run_op(1'b0, 64'h0000_0000_0000_00C3, 8'd0, 1'b1);
        run_op(1'b1, 64'd0, 8'd0, 1'b1);
        chk(pull_val == 64'hC3, "R8 stray start single byte", pull_val, 64'hC3);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule